// File: doc/BRIEF.md
# Pre/Post Trigger Capture Controller

This block sits in front of a sample RAM and records a parallel probe vector on every clock cycle while it is armed. A write pointer walks a ring whose length is the configured record depth. Each cycle a trigger input is compared with a selected condition. The block then works out how many of the depth slots hold samples taken before the trigger and how many hold samples taken from the trigger onward.

An arm pulse loads the configuration and restarts the ring at address 0. The block keeps writing until the trigger condition is met. It then writes the rest of the post-trigger part of the window and stops. When it stops it pulses a done flag and reports the ring address of the oldest sample in the window. A reader can then unroll the RAM from that address.

Only the first qualifying trigger after an arm is used. The block ignores every later trigger until the next arm pulse. Reading the RAM back is handled elsewhere.

Top module: `cap_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, ram_we_o and done_o are 0 and start_addr_o is 0.
- R2: A cycle with arm_i high loads the configuration and writes nothing. From the next cycle, each cycle's probe_i is presented on the RAM port one clock later with ram_we_o high. The address starts at 0, increments by one and wraps from depth-1 to 0.
- R3: The effective depth is depth_i clamped to the range 2 to DEPTH_MAX.
- R4: split_sel_i sets the pre-trigger count as floor(depth*k/10), where k is 3 for 00, 5 for 01, 7 for 10 and 5 for 11. The post-trigger count is depth minus pre, and it includes the trigger sample.
- R5: trig_mode_i selects the trigger condition: 00 rising edge, 01 falling edge, 10 either edge, 11 high level. An edge is judged against trig_i in the previous clock cycle. The mode is latched at arm.
- R6: The sample taken in the trigger cycle is followed by exactly post-1 further samples, and then writing stops. done_o is high for one cycle, in the same cycle as the last write.
- R7: When done_o rises, start_addr_o is the trigger address minus the pre count, modulo depth. If fewer pre-trigger samples than the pre count had been taken, it is the address of the oldest sample taken.
- R8: After the first trigger, further trigger activity has no effect. After done_o, nothing is written until the next arm_i. start_addr_o holds its value until the next done_o.
- R9: An arm_i pulse during a capture abandons that capture and restarts with the new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Load configuration and start a capture |
| trig_mode_i | input | 2 | Trigger condition select |
| split_sel_i | input | 2 | Pre/post split select |
| depth_i | input | $clog2(DEPTH_MAX)+1 | Requested record depth |
| probe_i | input | PROBE_W | Probe sample |
| trig_i | input | 1 | Trigger input |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | $clog2(DEPTH_MAX) | RAM write address |
| ram_data_o | output | PROBE_W | RAM write data |
| done_o | output | 1 | Capture complete, one-cycle pulse |
| start_addr_o | output | $clog2(DEPTH_MAX) | Oldest sample address of the window |

## Verification
The bench targets several corner cases, and each has a distinct failure sign:
- **Trigger before the pre region has filled.** A design that always subtracts the full pre count reports a start address that wrapped into never-written slots.
- **Trigger after the ring has wrapped several times.** An off-by-one in the wrap or in the subtraction shifts the start address.
- **Minimal window of one post sample.** Here done must coincide with the trigger write itself. A post counter loaded wrongly adds an extra write or never raises done.
- **Trigger pulses after the first.** A one-shot that is not cleared shows up as writes or a second done.
- **Re-arm in mid-capture.** Stale pointer or trigger state leaks into the new run.
- **Depth requests outside the legal range.** An unclamped depth changes the wrap point.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    TRG_RISE = 2'b00,
    TRG_FALL = 2'b01,
    TRG_ANY  = 2'b10,
    TRG_HIGH = 2'b11
  } trg_mode_e;

  typedef enum logic [1:0] {
    SPL_30  = 2'b00,
    SPL_50  = 2'b01,
    SPL_70  = 2'b10,
    SPL_RSV = 2'b11
  } split_e;
endpackage

// File: rtl/cap_trig_det.sv
module cap_trig_det
  import cap_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  trg_mode_e mode_i,
  input  logic      trig_i,
  output logic      hit_o
);
  logic trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_i;
  end

  always_comb begin
    unique case (mode_i)
      TRG_RISE: hit_o = trig_i & ~trig_q;
      TRG_FALL: hit_o = ~trig_i & trig_q;
      TRG_ANY:  hit_o = trig_i ^ trig_q;
      default:  hit_o = trig_i;
    endcase
  end
endmodule

// File: rtl/cap_split.sv
module cap_split
  import cap_pkg::*;
#(
  parameter int DEPTH_MAX = 64,
  localparam int CW = $clog2(DEPTH_MAX) + 1,
  localparam int MW = CW + 4
) (
  input  logic [CW-1:0] depth_i,
  input  split_e        sel_i,
  output logic [CW-1:0] depth_o,
  output logic [CW-1:0] pre_o,
  output logic [CW-1:0] post_o
);
  logic [MW-1:0] k;

  always_comb begin
    if (depth_i < CW'(2))              depth_o = CW'(2);
    else if (depth_i > CW'(DEPTH_MAX)) depth_o = CW'(DEPTH_MAX);
    else                               depth_o = depth_i;

    unique case (sel_i)
      SPL_30:  k = MW'(3);
      SPL_70:  k = MW'(7);
      default: k = MW'(5);
    endcase

    pre_o  = CW'((MW'(depth_o) * k) / MW'(10));
    post_o = depth_o - pre_o;
  end
endmodule

// File: rtl/cap_wr_ctrl.sv
module cap_wr_ctrl
  import cap_pkg::*;
#(
  parameter int PROBE_W   = 8,
  parameter int DEPTH_MAX = 64,
  localparam int AW = $clog2(DEPTH_MAX),
  localparam int CW = AW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arm_i,
  input  trg_mode_e          mode_i,
  input  logic [CW-1:0]      depth_i,
  input  logic [CW-1:0]      pre_i,
  input  logic [CW-1:0]      post_i,
  input  logic [PROBE_W-1:0] probe_i,
  input  logic               hit_i,
  output trg_mode_e          mode_q_o,
  output logic               ram_we_o,
  output logic [AW-1:0]      ram_addr_o,
  output logic [PROBE_W-1:0] ram_data_o,
  output logic               done_o,
  output logic [AW-1:0]      start_addr_o
);
  logic               armed_q, fired_q;
  logic [AW-1:0]      ptr_q, ptr_nxt, start_pend_q, start_calc;
  logic [CW-1:0]      fill_q, rem_q, depth_q, pre_q, post_q, back;
  logic [CW:0]        sum;
  trg_mode_e          mode_q;

  assign mode_q_o = mode_q;
  assign ptr_nxt  = ({1'b0, ptr_q} + CW'(1) == depth_q) ? '0 : ptr_q + AW'(1);

  // oldest sample: go back min(fill, pre) slots from the trigger address
  always_comb begin
    back = (fill_q >= pre_q) ? pre_q : fill_q;
    sum  = {2'b0, ptr_q} + {1'b0, depth_q} - {1'b0, back};
    if (sum >= {1'b0, depth_q}) start_calc = AW'(sum - {1'b0, depth_q});
    else                        start_calc = AW'(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q      <= 1'b0;
      fired_q      <= 1'b0;
      ptr_q        <= '0;
      fill_q       <= '0;
      rem_q        <= '0;
      depth_q      <= CW'(2);
      pre_q        <= '0;
      post_q       <= CW'(2);
      mode_q       <= TRG_RISE;
      start_pend_q <= '0;
      ram_we_o     <= 1'b0;
      ram_addr_o   <= '0;
      ram_data_o   <= '0;
      done_o       <= 1'b0;
      start_addr_o <= '0;
    end else begin
      ram_we_o <= 1'b0;
      done_o   <= 1'b0;
      if (arm_i) begin
        armed_q <= 1'b1;
        fired_q <= 1'b0;
        ptr_q   <= '0;
        fill_q  <= '0;
        depth_q <= depth_i;
        pre_q   <= pre_i;
        post_q  <= post_i;
        mode_q  <= mode_i;
      end else if (armed_q) begin
        ram_we_o   <= 1'b1;
        ram_addr_o <= ptr_q;
        ram_data_o <= probe_i;
        ptr_q      <= ptr_nxt;
        if (!fired_q) begin
          if (hit_i) begin
            fired_q      <= 1'b1;
            start_pend_q <= start_calc;
            rem_q        <= post_q - CW'(1);
            if (post_q == CW'(1)) begin
              done_o       <= 1'b1;
              start_addr_o <= start_calc;
              armed_q      <= 1'b0;
            end
          end else if (fill_q < depth_q) begin
            fill_q <= fill_q + CW'(1);
          end
        end else begin
          rem_q <= rem_q - CW'(1);
          if (rem_q == CW'(1)) begin
            done_o       <= 1'b1;
            start_addr_o <= start_pend_q;
            armed_q      <= 1'b0;
          end
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ram_we_o); // R6
  AST_STOP_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !ram_we_o); // R8
  AST_ADDR_IN_RING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ({1'b0, ram_addr_o} < depth_q)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && $past(ram_we_o)) |->
      (ram_addr_o == (({1'b0, $past(ram_addr_o)} + CW'(1) == depth_q) ? '0 : $past(ram_addr_o) + AW'(1)))); // R2
  AST_START_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(start_addr_o)); // R8
  AST_START_IN_RING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ({1'b0, start_addr_o} < depth_q)); // R7
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int PROBE_W   = 8,
  parameter int DEPTH_MAX = 64,
  localparam int AW = $clog2(DEPTH_MAX),
  localparam int CW = AW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arm_i,
  input  logic [1:0]         trig_mode_i,
  input  logic [1:0]         split_sel_i,
  input  logic [CW-1:0]      depth_i,
  input  logic [PROBE_W-1:0] probe_i,
  input  logic               trig_i,
  output logic               ram_we_o,
  output logic [AW-1:0]      ram_addr_o,
  output logic [PROBE_W-1:0] ram_data_o,
  output logic               done_o,
  output logic [AW-1:0]      start_addr_o
);
  logic [CW-1:0] depth_eff, pre_cnt, post_cnt;
  trg_mode_e     mode_q;
  logic          hit;

  cap_split #(.DEPTH_MAX(DEPTH_MAX)) u_split (
    .depth_i (depth_i),
    .sel_i   (split_e'(split_sel_i)),
    .depth_o (depth_eff),
    .pre_o   (pre_cnt),
    .post_o  (post_cnt)
  );

  cap_trig_det u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_q),
    .trig_i (trig_i),
    .hit_o  (hit)
  );

  cap_wr_ctrl #(.PROBE_W(PROBE_W), .DEPTH_MAX(DEPTH_MAX)) u_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arm_i        (arm_i),
    .mode_i       (trg_mode_e'(trig_mode_i)),
    .depth_i      (depth_eff),
    .pre_i        (pre_cnt),
    .post_i       (post_cnt),
    .probe_i      (probe_i),
    .hit_i        (hit),
    .mode_q_o     (mode_q),
    .ram_we_o     (ram_we_o),
    .ram_addr_o   (ram_addr_o),
    .ram_data_o   (ram_data_o),
    .done_o       (done_o),
    .start_addr_o (start_addr_o)
  );
endmodule

// File: tb/tb_cap_ctrl.sv
module tb_cap_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int DMAX = 64;
  localparam int AW = $clog2(DMAX);

  logic clk = 0, rst_n = 0, arm = 0, trig = 0;
  logic [1:0] mode = 0, split = 0;
  logic [AW:0] depth = 0;
  logic [PW-1:0] probe = 0;
  logic we, done;
  logic [AW-1:0] addr, start;
  logic [PW-1:0] data;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  string tag = "R1";

  // reference model state
  int m_armed = 0, m_fired = 0, m_ptr = 0, m_fill = 0, m_rem = 0;
  int m_depth = 2, m_pre = 0, m_mode = 0, m_prev = 0, m_sp = 0;
  int e_we = 0, e_addr = 0, e_data = 0, e_done = 0, e_start = 0;
  int seed = 7;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_ctrl #(.PROBE_W(PW), .DEPTH_MAX(DMAX)) dut (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .trig_mode_i(mode),
    .split_sel_i(split), .depth_i(depth), .probe_i(probe), .trig_i(trig),
    .ram_we_o(we), .ram_addr_o(addr), .ram_data_o(data), .done_o(done),
    .start_addr_o(start)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model();
    int hit, back;
    hit = 0;
    case (m_mode)
      0: hit = (trig && !m_prev);
      1: hit = (!trig && m_prev);
      2: hit = (int'(trig) != m_prev);
      default: hit = trig;
    endcase
    e_we = 0; e_done = 0;
    if (arm) begin
      m_depth = (depth < 2) ? 2 : (depth > DMAX) ? DMAX : int'(depth);
      m_pre = (split == 0) ? (m_depth*3)/10 : (split == 2) ? (m_depth*7)/10 : m_depth/2;
      m_mode = mode; m_ptr = 0; m_fill = 0; m_fired = 0; m_armed = 1;
    end else if (m_armed) begin
      e_we = 1; e_addr = m_ptr; e_data = probe;
      if (!m_fired) begin
        if (hit) begin
          back = (m_fill >= m_pre) ? m_pre : m_fill;
          m_sp = (m_ptr - back + m_depth) % m_depth;
          m_fired = 1;
          m_rem = m_depth - m_pre - 1;
        end else if (m_fill < m_depth) m_fill++;
      end else m_rem--;
      if (m_fired && m_rem == 0) begin
        e_done = 1; e_start = m_sp; m_armed = 0;
      end
      m_ptr = (m_ptr + 1) % m_depth;
    end
    m_prev = trig;
  endtask

  task automatic step(input logic a, input logic t);
    arm = a; trig = t;
    seed = (seed * 73 + 41) % 997;
    probe = PW'(seed);
    model();
    @(posedge clk);
    @(negedge clk);
    chk("ram_we_o (R2/R6)", we, e_we);
    chk("done_o (R6)", done, e_done);
    chk("start_addr_o (R7)", start, e_start);
    if (e_we) begin
      chk("ram_addr_o (R2)", addr, e_addr);
      chk("ram_data_o (R2)", data, e_data);
    end
  endtask

  // arm, hold trig at idle for n_low cycles, then at ~idle, total cycles after arm
  task automatic scen(input string t, input int md, input int sp, input int dp,
                      input logic idle, input int n_low, input int total);
    tag = t; mode = 2'(md); split = 2'(sp); depth = (AW+1)'(dp);
    step(1'b1, idle);
    for (int i = 0; i < total; i++) step(1'b0, (i < n_low) ? idle : ~idle);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired in %s", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("ram_we_o in reset (R1)", we, 0);
    chk("done_o in reset (R1)", done, 0);
    chk("start_addr_o in reset (R1)", start, 0);
    rst_n = 1;
    step(1'b0, 1'b0);

    scen("R2", 0, 1, 16, 1'b0, 20, 30);   // rising, 50/50
    scen("R7", 0, 2, 10, 1'b0, 25, 35);   // wrapped ring, 70/30
    scen("R4", 1, 0, 20, 1'b1, 8, 30);    // falling, 30/70
    scen("R5", 2, 1, 12, 1'b0, 15, 25);   // either edge
    scen("R5", 3, 0, 8, 1'b0, 3, 15);     // high level
    scen("R3", 0, 1, 0, 1'b0, 5, 10);     // depth below range
    scen("R3", 0, 1, 127, 1'b0, 70, 110); // depth above range
    scen("R6", 0, 2, 2, 1'b0, 4, 8);      // one post sample
    scen("R4", 0, 3, 9, 1'b0, 12, 20);    // reserved split
    scen("R7", 0, 2, 20, 1'b0, 3, 25);    // trigger before pre fills
    scen("R5", 1, 2, 6, 1'b1, 0, 10);     // edge judged vs pre-arm level

    // R8: repeated trigger pulses after the first
    tag = "R8"; mode = 0; split = 1; depth = 6;
    step(1'b1, 1'b0);
    for (int i = 0; i < 30; i++) step(1'b0, i[1]);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1);

    // R9: re-arm mid-capture with a new configuration
    tag = "R9"; mode = 0; split = 0; depth = 10;
    step(1'b1, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b0, i >= 4);
    mode = 1; split = 2; depth = 7;
    step(1'b1, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b0, i < 9);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule